// File: doc/BRIEF.md
# UART Receiver Status Flags

This block holds the status side of a UART receiver. A separate shifter hands it one result per received frame: the 9-bit frame word, a parity-OK bit and a frame strobe. It also gets a per-bit-period tick with the sampled line level. From these inputs it keeps four flags: parity error, idle line, receive data ready and muted. It also holds the last accepted frame word.

Software clears the parity error and idle flags in two steps. First it reads the status register while the flag is seen set. Then it makes a data-register access, which may be a read or a write. A flag that is raised again between those two steps survives the access.

With address-mark wakeup enabled, the receiver can sleep in mute mode. It drops ordinary traffic until an address frame carrying its own node address arrives. That frame is delivered with its parity result. Idle periods are detected in both run and mute mode. An idle period counts only when the line stays high for a full frame time. That time follows from the configured word length and stop-bit count.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset all four flags are 0 and the held frame word is 0.
- R2: An accepted frame sets the ready flag and loads its 9-bit word one cycle after the frame strobe. A data-register read clears the ready flag, and a data-register write leaves it unchanged.
- R3: An accepted frame whose parity-OK bit is 0 sets the parity error flag. The flag clears when a status read that saw it set is followed by a data-register read or write.
- R4: A data-register access clears no flag unless a status read saw that flag set since the last setting event. A status read made while the flag was 0, or a new setting event after the status read, leaves the flag set through the following access.
- R5: The idle flag rises on the bit tick that completes N consecutive high samples, where N = 1 + (9 if word length is 9 else 8) + (2 if two stop bits else 1). It does not rise one sample earlier. A low sample on the very next tick does not undo it. Detection is armed only once a frame has been received since reset.
- R6: The idle flag is raised at most once per idle period. After it is cleared, further high samples do not raise it again until a new frame has been received.
- R7: The idle flag clears through the same status-read-then-data-access sequence as the parity error flag.
- R8: With address marking enabled, a mute request enters mute mode. While muted, a frame that is not an address frame carrying the node address changes neither the ready flag, the parity error flag nor the held word, and the block stays muted.
- R9: While muted, an address frame whose low 4 bits equal the node address leaves mute mode. The frame is delivered as in R2, and a parity failure on it sets the parity error flag.
- R10: The idle flag is set per R5 in mute mode, and in run mode with address marking enabled.
- R11: In run mode with address marking enabled, an address frame with a different node address enters mute mode and is not delivered.
- R12: The address mark is bit 7 of the frame word for an 8-bit word length and bit 8 for a 9-bit word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word9 | input | 1 | 1 selects a 9-bit word, 0 an 8-bit word |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_addr_en | input | 1 | Enables address-mark wakeup |
| cfg_node_addr | input | ADDR_W | Own node address |
| mute_req | input | 1 | Request to enter mute mode |
| frm_valid | input | 1 | One-cycle strobe: a frame result is present |
| frm_data | input | 9 | Received frame word |
| frm_parity_ok | input | 1 | Parity check result of the frame |
| bit_tick | input | 1 | One strobe per bit period |
| line_level | input | 1 | Line level sampled at bit_tick |
| sr_rd | input | 1 | Status-register read strobe |
| dr_rd | input | 1 | Data-register read strobe |
| dr_wr | input | 1 | Data-register write strobe |
| rx_data | output | 9 | Last accepted frame word |
| flag_pe | output | 1 | Parity error flag |
| flag_idle | output | 1 | Idle line flag |
| flag_rxne | output | 1 | Received data ready flag |
| flag_muted | output | 1 | Mute mode state |

## Verification
The assertions check a set of cycle-local links on every cycle:
- an accepted frame raises the ready flag, and a parity failure on it raises the parity error flag;
- a wake event clears mute;
- a muted, non-waking frame is never accepted;
- the idle flag only rises after a detector hit;
- the parity error and idle flags only fall after a data-register access.

Only the bench scenarios can show the sequence-dependent behaviour:
- the exact idle length for each word and stop-bit setting;
- an idle period being reported once and re-armed by a frame;
- a clear being withheld when the status read saw the flag clear or a new error arrived between the two steps;
- the mark bit moving with word length.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;
  localparam int FRAME_W = 9;
  localparam int LEN_W   = 4;

  // Bit periods a line must stay high to count as an idle frame
  function automatic logic [LEN_W-1:0] idle_span(input logic word9, input logic stop2);
    logic [LEN_W-1:0] data_bits;
    logic [LEN_W-1:0] stop_bits;
    data_bits = word9 ? LEN_W'(9) : LEN_W'(8);
    stop_bits = stop2 ? LEN_W'(2) : LEN_W'(1);
    return LEN_W'(1) + data_bits + stop_bits;
  endfunction

  // Address mark sits in the top bit of the configured word
  function automatic logic mark_of(input logic [FRAME_W-1:0] word, input logic word9);
    return word9 ? word[8] : word[7];
  endfunction
endpackage

// File: rtl/rxf_idle_det.sv
module rxf_idle_det
  import uart_rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             line_level,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] span,
  output logic             hit
);
  logic [LEN_W-1:0] run_cnt;
  logic             armed;

  // Hit on the tick that completes the span; a later low sample cannot undo it
  assign hit = bit_tick && line_level && armed && !frm_valid &&
               ((run_cnt + LEN_W'(1)) >= span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      armed   <= 1'b0;
    end else if (frm_valid) begin
      run_cnt <= '0;
      armed   <= 1'b1;
    end else if (bit_tick) begin
      if (!line_level) run_cnt <= '0;
      else if (run_cnt < span) run_cnt <= run_cnt + LEN_W'(1);
      if (hit) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_mute_ctl.sv
module rxf_mute_ctl
  import uart_rxf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word9,
  input  logic               addr_en,
  input  logic [ADDR_W-1:0]  node_addr,
  input  logic               mute_req,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               muted,
  output logic               accept,
  output logic               wake
);
  logic is_addr;
  logic match;

  assign is_addr = addr_en && mark_of(frm_data, word9);
  assign match   = (frm_data[ADDR_W-1:0] == node_addr);
  assign wake    = frm_valid && muted && is_addr && match;
  assign accept  = frm_valid && (muted ? wake : !(is_addr && !match));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) muted <= 1'b0;
    else if (wake) muted <= 1'b0;
    else if (!muted && frm_valid && is_addr && !match) muted <= 1'b1;
    else if (!muted && mute_req && addr_en) muted <= 1'b1;
  end
endmodule

// File: rtl/rxf_seq_flag.sv
module rxf_seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic sr_rd,
  input  logic dr_acc,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_ev) begin
      // A fresh event cancels any half-done clear sequence
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (dr_acc && armed) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (sr_rd && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rxf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_word9,
  input  logic               cfg_stop2,
  input  logic               cfg_addr_en,
  input  logic [ADDR_W-1:0]  cfg_node_addr,
  input  logic               mute_req,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  input  logic               frm_parity_ok,
  input  logic               bit_tick,
  input  logic               line_level,
  input  logic               sr_rd,
  input  logic               dr_rd,
  input  logic               dr_wr,
  output logic [FRAME_W-1:0] rx_data,
  output logic               flag_pe,
  output logic               flag_idle,
  output logic               flag_rxne,
  output logic               flag_muted
);
  localparam int NSEQ = 2;

  logic             ev_accept;
  logic             ev_wake;
  logic             ev_idle_hit;
  logic             ev_par_err;
  logic [LEN_W-1:0] span;
  logic [NSEQ-1:0]  seq_set;
  logic [NSEQ-1:0]  seq_flag;

  assign span       = idle_span(cfg_word9, cfg_stop2);
  assign ev_par_err = ev_accept && !frm_parity_ok;

  rxf_idle_det u_idle (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_level(line_level),
    .frm_valid(frm_valid), .span(span), .hit(ev_idle_hit)
  );

  rxf_mute_ctl #(.ADDR_W(ADDR_W)) u_mute (
    .clk(clk), .rst_n(rst_n), .word9(cfg_word9), .addr_en(cfg_addr_en),
    .node_addr(cfg_node_addr), .mute_req(mute_req), .frm_valid(frm_valid),
    .frm_data(frm_data), .muted(flag_muted), .accept(ev_accept), .wake(ev_wake)
  );

  // Index 0: parity error, index 1: idle
  assign seq_set = {ev_idle_hit, ev_par_err};

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    rxf_seq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_ev(seq_set[g]), .sr_rd(sr_rd),
      .dr_acc(dr_rd || dr_wr), .flag(seq_flag[g])
    );
  end

  assign flag_pe   = seq_flag[0];
  assign flag_idle = seq_flag[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_rxne <= 1'b0;
      rx_data   <= '0;
    end else if (ev_accept) begin
      flag_rxne <= 1'b1;
      rx_data   <= frm_data;
    end else if (dr_rd) begin
      flag_rxne <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_valid,
  input logic frm_parity_ok,
  input logic dr_rd,
  input logic dr_wr,
  input logic flag_pe,
  input logic flag_idle,
  input logic flag_rxne,
  input logic flag_muted,
  input logic ev_accept,
  input logic ev_wake,
  input logic ev_idle_hit
);
  // R2
  accept_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> flag_rxne);

  // R3
  parity_fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !frm_parity_ok) |=> flag_pe);

  // R4
  pe_clear_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_pe) |-> $past(dr_rd || dr_wr));

  // R7
  idle_clear_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_idle) |-> $past(dr_rd || dr_wr));

  // R6
  idle_rise_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_idle) |-> $past(ev_idle_hit));

  // R8
  muted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_muted && frm_valid && !ev_wake) |-> !ev_accept);

  // R9
  wake_unmutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> !flag_muted);
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_parity_ok(frm_parity_ok),
  .dr_rd(dr_rd), .dr_wr(dr_wr), .flag_pe(flag_pe), .flag_idle(flag_idle),
  .flag_rxne(flag_rxne), .flag_muted(flag_muted), .ev_accept(ev_accept),
  .ev_wake(ev_wake), .ev_idle_hit(ev_idle_hit)
);

// File: tb/tb_uart_rx_flags.sv
module tb_uart_rx_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_word9 = 0, cfg_stop2 = 0, cfg_addr_en = 0;
  logic [3:0] cfg_node_addr = 4'd5;
  logic       mute_req = 0, frm_valid = 0, frm_parity_ok = 1;
  logic [8:0] frm_data = '0;
  logic       bit_tick = 0, line_level = 1, sr_rd = 0, dr_rd = 0, dr_wr = 0;
  logic [8:0] rx_data;
  logic       flag_pe, flag_idle, flag_rxne, flag_muted;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic       pe, idle, rxne, muted;
    logic [8:0] data;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  uart_rx_flags dut (
    .clk(clk), .rst_n(rst_n), .cfg_word9(cfg_word9), .cfg_stop2(cfg_stop2),
    .cfg_addr_en(cfg_addr_en), .cfg_node_addr(cfg_node_addr), .mute_req(mute_req),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_parity_ok(frm_parity_ok),
    .bit_tick(bit_tick), .line_level(line_level), .sr_rd(sr_rd), .dr_rd(dr_rd),
    .dr_wr(dr_wr), .rx_data(rx_data), .flag_pe(flag_pe), .flag_idle(flag_idle),
    .flag_rxne(flag_rxne), .flag_muted(flag_muted)
  );

  // Bench's own idle length: start bit, data bits, stop bits
  function automatic int idle_need(input bit w9, input bit s2);
    int n;
    n = 1;
    n += w9 ? 9 : 8;
    n += s2 ? 2 : 1;
    return n;
  endfunction

  task automatic expect_st(input string tag, input logic pe, input logic idle,
                           input logic rxne, input logic muted, input logic [8:0] data);
    exp_t e;
    e.tag = tag; e.pe = pe; e.idle = idle; e.rxne = rxne; e.muted = muted; e.data = data;
    exp_q.push_back(e);
  endtask

  // Monitor: pops expected items just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if ({flag_pe, flag_idle, flag_rxne, flag_muted} !== {e.pe, e.idle, e.rxne, e.muted} ||
            rx_data !== e.data) begin
          errors++;
          $display("FAIL %s: actual pe=%b idle=%b rxne=%b muted=%b data=%h expected pe=%b idle=%b rxne=%b muted=%b data=%h",
                   e.tag, flag_pe, flag_idle, flag_rxne, flag_muted, rx_data,
                   e.pe, e.idle, e.rxne, e.muted, e.data);
        end
      end
    end
  end

  task automatic frame(input logic [8:0] d, input logic pok);
    frm_valid = 1; frm_data = d; frm_parity_ok = pok;
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic strobe_sr(); sr_rd = 1; @(negedge clk); sr_rd = 0; endtask
  task automatic strobe_rd(); dr_rd = 1; @(negedge clk); dr_rd = 0; endtask
  task automatic strobe_wr(); dr_wr = 1; @(negedge clk); dr_wr = 0; endtask
  task automatic req_mute(); mute_req = 1; @(negedge clk); mute_req = 0; endtask

  task automatic ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; line_level = lvl;
      @(negedge clk);
      bit_tick = 0; line_level = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_st("R1 reset", 0, 0, 0, 0, 9'h000);
    rst_n = 1;
    @(negedge clk);

    frame(9'h0A5, 1);
    expect_st("R2 frame loads", 0, 0, 1, 0, 9'h0A5);
    strobe_wr();
    expect_st("R2 write keeps ready", 0, 0, 1, 0, 9'h0A5);
    strobe_rd();
    expect_st("R2 read clears ready", 0, 0, 0, 0, 9'h0A5);

    frame(9'h033, 0);
    expect_st("R3 parity sets", 1, 0, 1, 0, 9'h033);
    strobe_wr();
    expect_st("R4 write without status read", 1, 0, 1, 0, 9'h033);
    strobe_sr(); strobe_rd();
    expect_st("R3 sequence clears", 0, 0, 0, 0, 9'h033);

    strobe_sr();
    frame(9'h011, 0);
    strobe_wr();
    expect_st("R4 status read saw zero", 1, 0, 1, 0, 9'h011);
    strobe_sr();
    frame(9'h012, 0);
    strobe_wr();
    expect_st("R4 new error after status read", 1, 0, 1, 0, 9'h012);
    strobe_sr(); strobe_rd();
    expect_st("R3 clear after rearm", 0, 0, 0, 0, 9'h012);

    ticks(idle_need(0, 0) - 1, 1);
    expect_st("R5 one short of idle", 0, 0, 0, 0, 9'h012);
    ticks(1, 1);
    expect_st("R5 idle at full length", 0, 1, 0, 0, 9'h012);
    ticks(1, 0);
    expect_st("R5 start bit right after idle", 0, 1, 0, 0, 9'h012);
    ticks(15, 1);
    strobe_sr(); strobe_rd();
    expect_st("R7 idle clears", 0, 0, 0, 0, 9'h012);
    ticks(15, 1);
    expect_st("R6 no second idle", 0, 0, 0, 0, 9'h012);

    frame(9'h044, 1);
    strobe_rd();
    cfg_word9 = 1; cfg_stop2 = 1;
    ticks(idle_need(1, 1) - 1, 1);
    expect_st("R5 nine-bit two-stop short", 0, 0, 0, 0, 9'h044);
    ticks(1, 1);
    expect_st("R6 rearmed by frame, R5 long span", 0, 1, 0, 0, 9'h044);
    strobe_sr(); strobe_rd();
    expect_st("R7 idle clears again", 0, 0, 0, 0, 9'h044);

    cfg_word9 = 0; cfg_stop2 = 0; cfg_addr_en = 1;
    req_mute();
    expect_st("R8 mute entry", 0, 0, 0, 1, 9'h044);
    frame(9'h022, 1);
    frame(9'h083, 1);
    frame(9'h022, 0);
    expect_st("R8 muted frames ignored", 0, 0, 0, 1, 9'h044);
    ticks(idle_need(0, 0), 1);
    expect_st("R10 idle while muted", 0, 1, 0, 1, 9'h044);
    strobe_sr(); strobe_rd();
    expect_st("R10 idle clears while muted", 0, 0, 0, 1, 9'h044);

    frame(9'h085, 0);
    expect_st("R9 wake with parity error", 1, 0, 1, 0, 9'h085);
    strobe_sr(); strobe_rd();
    expect_st("R9 cleared after wake", 0, 0, 0, 0, 9'h085);

    frame(9'h086, 1);
    expect_st("R11 foreign address mutes", 0, 0, 0, 1, 9'h085);
    cfg_word9 = 1;
    frame(9'h085, 1);
    expect_st("R12 bit7 is data in 9-bit mode", 0, 0, 0, 1, 9'h085);
    frame(9'h105, 1);
    expect_st("R12 bit8 mark wakes", 0, 0, 1, 0, 9'h105);
    strobe_rd();
    ticks(idle_need(1, 0), 1);
    expect_st("R10 idle in run mode with marking", 0, 1, 0, 0, 9'h105);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule